// File: doc/BRIEF.md
# Shared-Clock Two-Port RAM with Selectable Read-During-Write Results

This block is a synchronous memory with two fully symmetric ports, A and B, on one clock. Either port can write one word, read one word, or do both in the same cycle, each at its own address. Requests pass through an input register. The array is written and read on the next edge, and the read word is captured in a per-port output register. Read data therefore appears two clock edges after the request is presented.

Elaboration parameters fix what a port sees when a read meets a write at the same address in the same cycle. Each port has its own same-port choice: it returns either the word it is writing or the word stored before the write. A single mixed-port choice covers a port that reads an address the other port is writing. In that case the reader gets either the stored word or an explicitly unknown result.

When both ports write one address in the same cycle, that word is marked unknown. Every later read of it reports unknown until a single port writes it again. Unknown results are not carried as X values. Each stored word and each read output has a flag beside it, and a raised flag means the data bits carry no meaning.

Top module: `tdp_ram`

## Requirements
- R1: After synchronous reset, both read data outputs are zero and both unknown flags are low.
- R2: A read presented before clock edge k shows its result on the read outputs after edge k+1. The result does not appear after edge k alone.
- R3: A port whose read enable is low at request time keeps its read data and unknown flag unchanged in the cycle its result would have landed.
- R4: With a port's same-port mode set to new-data (`RDW_NEW`), a read and write by that port to its address in one request returns the word being written, with the unknown flag low.
- R5: With a port's same-port mode set to old-data (`RDW_OLD`), a read and write by that port in one request returns the word stored before the write, including its unknown flag.
- R6: With the mixed mode set to old-data (`MIX_OLD`), a port that reads an address the other port writes in the same request returns the previously stored word and flag.
- R7: With the mixed mode set to don't-care (`MIX_DC`), a port that reads, without writing, an address the other port writes in the same request reports unknown.
- R8: Both ports writing the same address in one request leave that word unknown. Reads of it report unknown until exactly one port writes it, after which it reads back cleanly.
- R9: Writes by the two ports to different addresses in one request both take effect. A later read returns the most recently written value.
- R10: An old-data result (same-port or mixed) of a word that is currently unknown reports unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write word |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write word |
| a_rdata | output | DW | Port A registered read word |
| a_unk | output | 1 | Port A read result is unknown |
| b_rdata | output | DW | Port B registered read word |
| b_unk | output | 1 | Port B read result is unknown |

## Verification
The hardest situations to reach are the ones where two rules meet in one cycle. Examples are a collision on a word that a port is also reading back in old-data mode, or a mixed-port old-data read of a word already poisoned by an earlier collision. These combinations only show up as a flag two edges later. The stimulus first fills the memory with distinct words from both ports at once. It then forces a same-address double write with both ports also reading, re-reads the poisoned word through both ports, and overwrites it from one port while the other reads it. It closes with a sweep over every pair of write-address and read-address. All eight combinations of the three mode parameters run side by side on identical stimulus, each against its own reference array with unknown flags.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    // Same-port read-during-write policy
    typedef enum logic {
        RDW_NEW = 1'b0,
        RDW_OLD = 1'b1
    } same_rdw_e;

    // Mixed-port read-during-write policy
    typedef enum logic {
        MIX_OLD = 1'b0,
        MIX_DC  = 1'b1
    } mixed_rdw_e;

    // Where a port's read word comes from this cycle
    typedef enum logic [1:0] {
        SRC_MEM = 2'd0,
        SRC_OWN = 2'd1,
        SRC_UNK = 2'd2
    } rd_src_e;

    function automatic rd_src_e pick_src(
        input logic       own_wr,
        input logic       oth_wr_same,
        input same_rdw_e  sm,
        input mixed_rdw_e mx
    );
        if (own_wr)
            return (sm == RDW_NEW) ? SRC_OWN : SRC_MEM;
        if (oth_wr_same)
            return (mx == MIX_DC) ? SRC_UNK : SRC_MEM;
        return SRC_MEM;
    endfunction

endpackage

// File: rtl/tdp_in_reg.sv
module tdp_in_reg #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          q_we,
    output logic          q_re,
    output logic [AW-1:0] q_addr,
    output logic [DW-1:0] q_wdata
);
    typedef struct packed {
        logic          we;
        logic          re;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } req_t;

    req_t r;

    always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= '{we: we, re: re, addr: addr, wdata: wdata};
    end

    assign q_we    = r.we;
    assign q_re    = r.re;
    assign q_addr  = r.addr;
    assign q_wdata = r.wdata;
endmodule

// File: rtl/tdp_core.sv
module tdp_core
    import tdp_pkg::*;
#(
    parameter int         AW     = 6,
    parameter int         DW     = 16,
    parameter same_rdw_e  SAME_A = RDW_NEW,
    parameter same_rdw_e  SAME_B = RDW_OLD,
    parameter mixed_rdw_e MIXED  = MIX_OLD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           we,
    input  logic [1:0][AW-1:0]   addr,
    input  logic [1:0][DW-1:0]   wdata,
    output logic [1:0][DW-1:0]   rd_data,
    output logic [1:0]           rd_unk
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem_d [DEPTH];
    logic [DEPTH-1:0] mem_u;
    logic             collide;

    assign collide = we[0] && we[1] && (addr[0] == addr[1]);

    // Poison flags: set by a double write, cleared by a single-port write
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_u <= '0;
        end else if (collide) begin
            mem_u[addr[0]] <= 1'b1;
        end else begin
            for (int p = 0; p < 2; p++)
                if (we[p]) mem_u[addr[p]] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++)
            if (we[p]) mem_d[addr[p]] <= wdata[p];
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        localparam int        O  = 1 - p;
        localparam same_rdw_e SM = (p == 0) ? SAME_A : SAME_B;
        rd_src_e src;

        always_comb begin
            src = pick_src(we[p], we[O] && (addr[O] == addr[p]), SM, MIXED);
            case (src)
                SRC_OWN: begin rd_data[p] = wdata[p];        rd_unk[p] = 1'b0;            end
                SRC_UNK: begin rd_data[p] = mem_d[addr[p]];  rd_unk[p] = 1'b1;            end
                default: begin rd_data[p] = mem_d[addr[p]];  rd_unk[p] = mem_u[addr[p]];  end
            endcase
        end
    end

    // R8
    collide_poison_chk: assert property (@(posedge clk) disable iff (rst)
        collide |=> mem_u[$past(addr[0])]);

    // R9
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we[0] && !collide) |=>
            (mem_d[$past(addr[0])] == $past(wdata[0])) && !mem_u[$past(addr[0])]);
endmodule

// File: rtl/tdp_out_reg.sv
module tdp_out_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          din_unk,
    output logic [DW-1:0] q,
    output logic          q_unk
);
    typedef struct packed {
        logic          unk;
        logic [DW-1:0] data;
    } word_t;

    word_t r;

    always_ff @(posedge clk) begin
        if (rst)       r <= '0;
        else if (load) r <= '{unk: din_unk, data: din};
    end

    assign q     = r.data;
    assign q_unk = r.unk;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(q) && $stable(q_unk)));
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
    import tdp_pkg::*;
#(
    parameter int         AW     = 6,
    parameter int         DW     = 16,
    parameter same_rdw_e  SAME_A = RDW_NEW,
    parameter same_rdw_e  SAME_B = RDW_OLD,
    parameter mixed_rdw_e MIXED  = MIX_OLD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          b_we,
    input  logic          b_re,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_unk,
    output logic [DW-1:0] b_rdata,
    output logic          b_unk
);
    logic [1:0]           i_we, i_re, r_we, r_re, o_unk, c_unk;
    logic [1:0][AW-1:0]   i_addr, r_addr;
    logic [1:0][DW-1:0]   i_wdata, r_wdata, c_data, o_data;

    assign i_we    = {b_we, a_we};
    assign i_re    = {b_re, a_re};
    assign i_addr  = {b_addr, a_addr};
    assign i_wdata = {b_wdata, a_wdata};

    for (genvar p = 0; p < 2; p++) begin : g_port
        localparam int        O  = 1 - p;
        localparam same_rdw_e PM = (p == 0) ? SAME_A : SAME_B;

        tdp_in_reg #(.AW(AW), .DW(DW)) u_in (
            .clk(clk), .rst(rst),
            .we(i_we[p]), .re(i_re[p]), .addr(i_addr[p]), .wdata(i_wdata[p]),
            .q_we(r_we[p]), .q_re(r_re[p]), .q_addr(r_addr[p]), .q_wdata(r_wdata[p])
        );

        tdp_out_reg #(.DW(DW)) u_out (
            .clk(clk), .rst(rst), .load(r_re[p]),
            .din(c_data[p]), .din_unk(c_unk[p]),
            .q(o_data[p]), .q_unk(o_unk[p])
        );

        if (PM == RDW_NEW) begin : g_new_chk
            // R4
            own_new_data_chk: assert property (@(posedge clk) disable iff (rst)
                (r_we[p] && r_re[p]) |=> (o_data[p] == $past(r_wdata[p])) && !o_unk[p]);
        end

        if (MIXED == MIX_DC) begin : g_dc_chk
            // R7
            mixed_dc_unk_chk: assert property (@(posedge clk) disable iff (rst)
                (r_re[p] && !r_we[p] && r_we[O] && (r_addr[O] == r_addr[p])) |=> o_unk[p]);
        end
    end

    tdp_core #(
        .AW(AW), .DW(DW), .SAME_A(SAME_A), .SAME_B(SAME_B), .MIXED(MIXED)
    ) u_core (
        .clk(clk), .rst(rst),
        .we(r_we), .addr(r_addr), .wdata(r_wdata),
        .rd_data(c_data), .rd_unk(c_unk)
    );

    assign a_rdata = o_data[0];
    assign a_unk   = o_unk[0];
    assign b_rdata = o_data[1];
    assign b_unk   = o_unk[1];
endmodule

// File: tb/tb_tdp_ram.sv
module tb_tdp_ram;
    import tdp_pkg::*;

    localparam int AW = 3;
    localparam int DW = 8;
    localparam int NA = 1 << AW;
    localparam int NC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          a_we = 0, a_re = 0, b_we = 0, b_re = 0;
    logic [AW-1:0] a_addr = 0, b_addr = 0;
    logic [DW-1:0] a_wdata = 0, b_wdata = 0;

    logic [DW-1:0] qd [NC][2];
    logic          qu [NC][2];

    // cfg bit0: A old-data, bit1: B old-data, bit2: mixed don't-care
    for (genvar g = 0; g < NC; g++) begin : g_cfg
        tdp_ram #(
            .AW(AW), .DW(DW),
            .SAME_A((g % 2) != 0 ? RDW_OLD : RDW_NEW),
            .SAME_B(((g / 2) % 2) != 0 ? RDW_OLD : RDW_NEW),
            .MIXED((g / 4) != 0 ? MIX_DC : MIX_OLD)
        ) dut (
            .clk(clk), .rst(rst),
            .a_we(a_we), .a_re(a_re), .a_addr(a_addr), .a_wdata(a_wdata),
            .b_we(b_we), .b_re(b_re), .b_addr(b_addr), .b_wdata(b_wdata),
            .a_rdata(qd[g][0]), .a_unk(qu[g][0]),
            .b_rdata(qd[g][1]), .b_unk(qu[g][1])
        );
    end

    // reference model
    logic [DW-1:0] md [NC][NA];
    logic          mu [NC][NA];
    logic [DW-1:0] eq [NC][2];
    logic          eu [NC][2];
    string         etag [2];
    logic [DW-1:0] pq [NC][2];
    logic          pu [NC][2];
    logic          pre [2];
    string         ptag [2];
    logic          pvalid = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check_all();
        for (int c = 0; c < NC; c++) begin
            for (int p = 0; p < 2; p++) begin
                n_chk++;
                if (eu[c][p]) begin
                    if (!qu[c][p]) begin
                        n_bad++;
                        $display("FAIL %s cfg%0d port%0d: unk=%0b data=%h, expected unk=1",
                                 etag[p], c, p, qu[c][p], qd[c][p]);
                    end
                end else if (qu[c][p] || qd[c][p] !== eq[c][p]) begin
                    n_bad++;
                    $display("FAIL %s cfg%0d port%0d: unk=%0b data=%h, expected unk=0 data=%h",
                             etag[p], c, p, qu[c][p], qd[c][p], eq[c][p]);
                end
            end
        end
    endtask

    task automatic step(input logic wa, input logic ra, input int aa, input int da,
                        input logic wb, input logic rb, input int ab, input int db,
                        input string tag);
        logic [1:0]          w, r;
        logic [1:0][AW-1:0]  ad;
        logic [1:0][DW-1:0]  dt;
        w = {wb, wa}; r = {rb, ra};
        ad = {AW'(ab), AW'(aa)}; dt = {DW'(db), DW'(da)};
        @(negedge clk);
        check_all();
        if (pvalid) begin
            for (int p = 0; p < 2; p++) begin
                etag[p] = pre[p] ? ptag[p] : "R3";
                if (pre[p])
                    for (int c = 0; c < NC; c++) begin
                        eq[c][p] = pq[c][p];
                        eu[c][p] = pu[c][p];
                    end
            end
        end
        for (int p = 0; p < 2; p++) begin
            pre[p]  = r[p];
            ptag[p] = tag;
            for (int c = 0; c < NC; c++) begin
                bit old_same;
                bit mix_dc;
                old_same = (p == 0) ? c[0] : c[1];
                mix_dc   = c[2];
                if (w[p]) begin
                    if (old_same) begin pq[c][p] = md[c][ad[p]]; pu[c][p] = mu[c][ad[p]]; end
                    else          begin pq[c][p] = dt[p];        pu[c][p] = 1'b0;         end
                end else if (w[1-p] && ad[1-p] == ad[p] && mix_dc) begin
                    pq[c][p] = '0; pu[c][p] = 1'b1;
                end else begin
                    pq[c][p] = md[c][ad[p]]; pu[c][p] = mu[c][ad[p]];
                end
            end
        end
        pvalid = 1'b1;
        for (int c = 0; c < NC; c++) begin
            if (w[0] && w[1] && ad[0] == ad[1]) begin
                mu[c][ad[0]] = 1'b1;
            end else begin
                for (int p = 0; p < 2; p++)
                    if (w[p]) begin md[c][ad[p]] = dt[p]; mu[c][ad[p]] = 1'b0; end
            end
        end
        a_we = wa; a_re = ra; a_addr = ad[0]; a_wdata = dt[0];
        b_we = wb; b_re = rb; b_addr = ad[1]; b_wdata = dt[1];
    endtask

    initial begin
        #(8 * 5000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            for (int a = 0; a < NA; a++) begin md[c][a] = '0; mu[c][a] = 1'b0; end
            for (int p = 0; p < 2; p++) begin eq[c][p] = '0; eu[c][p] = 1'b0; end
        end
        etag[0] = "R1"; etag[1] = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 checked on first step; R9 fill from both ports, distinct addresses
        for (int a = 0; a < 4; a++)
            step(1, 0, a, 'h10 + a, 1, 0, a + 4, 'h20 + a, "R9");
        // R2 read back with two-edge latency
        for (int a = 0; a < NA; a++)
            step(0, 1, a, 0, 0, 1, NA - 1 - a, 0, "R2");
        // R3 idle ports keep output while unrelated writes happen
        step(1, 0, 3, 'h33, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 0, 7, 'h77, "R3");
        // R4 R5 same-port read-during-write
        step(1, 1, 1, 'hA1, 1, 1, 5, 'hB5, "R4 R5");
        step(0, 1, 5, 0, 0, 1, 1, 0, "R9");
        // R6 R7 mixed-port, both directions
        step(1, 0, 2, 'hC2, 0, 1, 2, 0, "R6 R7");
        step(0, 1, 6, 0, 1, 0, 6, 'hD6, "R6 R7");
        step(0, 1, 6, 0, 0, 1, 2, 0, "R9");
        // R8 collision with both ports also reading
        step(1, 1, 0, 'hDD, 1, 1, 0, 'hEE, "R8");
        step(0, 1, 0, 0, 0, 1, 0, 0, "R8");
        // R10 old-data reads of a poisoned word
        step(1, 1, 0, 'h5A, 0, 0, 0, 0, "R10");
        step(1, 1, 4, 'h44, 1, 1, 4, 'h45, "R8");
        step(1, 0, 4, 'h46, 0, 1, 4, 0, "R10");
        step(1, 0, 0, 'h55, 0, 1, 0, 0, "R6 R7");
        step(0, 1, 4, 0, 0, 1, 0, 0, "R8");
        // sweep: A writes aa while B reads ab; then the reverse
        for (int aa = 0; aa < NA; aa++)
            for (int ab = 0; ab < NA; ab++)
                step(1, 1, aa, 'h80 | (aa << 3) | ab, 0, 1, ab, 0, "R6 R7");
        for (int aa = 0; aa < NA; aa++)
            for (int ab = 0; ab < NA; ab++)
                step(0, 1, aa, 0, 1, 1, ab, 'h40 | (ab << 3) | aa, "R6 R7");
        // drain pipeline
        step(0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R3");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule